// File: doc/BRIEF.md
# Power mode sequencing controller

The block keeps the global power mode of a small system-on-chip. It supports four modes: Active, Alternate Active, Sleep and Hibernate. Software picks a mode by writing a code to a mode register. Two template registers give the resource enables: one for Active and one for Alternate Active. In each template, bit 0 is the CPU enable and the bits above it drive one clock gate per resource. In Sleep, Hibernate and the transitional waking state, every enable is held low. The templates keep their contents and apply again when the system returns to Active.

Wakeup inputs are filtered according to the current mode. In Alternate Active, any interrupt or wake source returns the system to Active on the next cycle. In Sleep, any of the five wake sources starts a wakeup. In Hibernate, only the pin interrupt starts a wakeup. After a wakeup from Sleep or Hibernate, the block reports a waking state for a programmable number of cycles and then enters Active. Every wakeup sets the CPU bit of the Active template, so the CPU always runs again after a wake, whatever software had written to that bit. Regulators, power switches and clock generation are outside the block and appear only as its enable outputs.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (Active), cpu_en_o is 1, all clk_en_o bits are 1, and both templates reset to all ones.
- R2: Mode codes on mode_o are: 0 Active, 1 Alternate Active, 2 Sleep, 3 Hibernate, 4 Waking. A write to address 0 in Active or Alternate Active enters the mode given by wr_data_i[1:0]. The new mode shows on mode_o after the write edge.
- R3: In Active, clk_en_o equals bits [N_RES:1] of the template at address 1, and cpu_en_o equals its bit 0. In Alternate Active, the same applies to the template at address 2.
- R4: In Sleep, Hibernate and Waking, clk_en_o is all zeros and cpu_en_o is 0. Template writes in these modes are kept and take effect on the return to Active.
- R5: In Alternate Active, irq_i or any wake_i bit moves the mode to Active on the next edge with cpu_en_o high.
- R6: In Active, irq_i or any wake_i bit sets the CPU bit of the Active template, so cpu_en_o returns high.
- R7: In Sleep, any one of wake_i[0] (pin), [1] (comparator), [2] (I2C address match), [3] (real-time clock) or [4] (timewheel) starts a wakeup.
- R8: In Hibernate, only wake_i[0] starts a wakeup. The other wake_i bits and irq_i leave the mode at Hibernate.
- R9: A wakeup reports Waking (4) for exactly D+1 cycles and then Active with cpu_en_o high. D is bits [DLY_W-1:0] of address 3 for a wake from Sleep, or bits [2*DLY_W-1:DLY_W] for a wake from Hibernate.
- R10: Mode writes in Sleep, Hibernate or Waking are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 mode, 1 Active template, 2 Alternate template, 3 wake delays |
| wr_data_i | input | 2*DLY_W | Write data |
| wake_i | input | 5 | Wake sources: pin, comparator, I2C match, RTC, timewheel |
| irq_i | input | 1 | Any interrupt |
| clk_en_o | output | N_RES | Resource clock-gate enables |
| cpu_en_o | output | 1 | CPU enable |
| mode_o | output | 3 | Current mode code |

## Verification
The hardest case to reach is an event that arrives while the block cannot accept it. Examples are a mode write during the waking countdown, a non-pin source in Hibernate, and a template rewrite while all enables are forced low. The stimulus parks the block in each of these states with chosen delays. It then issues the ignored events and watches mode_o cycle by cycle to the exact edge where Active returns. The bench sweeps every wake source and several delay values for both wakeup paths. It also sweeps all template values in both running modes.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_ACT  = 3'd0,
    PM_ALT  = 3'd1,
    PM_SLP  = 3'd2,
    PM_HIB  = 3'd3,
    PM_WAKE = 3'd4
  } pm_mode_e;

  localparam int unsigned N_SRC   = 5;
  localparam int unsigned SRC_PIN = 0;

  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_TACT = 2'd1;
  localparam logic [1:0] A_TALT = 2'd2;
  localparam logic [1:0] A_DLY  = 2'd3;
endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs #(
  parameter int unsigned TW      = 8,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned SLP_RST = 4,
  parameter int unsigned HIB_RST = 20,
  localparam int unsigned DW     = 2 * DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             cpu_set_i,
  output logic [TW-1:0]    act_tmpl_o,
  output logic [TW-1:0]    alt_tmpl_o,
  output logic [DLY_W-1:0] dly_slp_o,
  output logic [DLY_W-1:0] dly_hib_o
);
  import pwr_mode_pkg::*;

  logic [TW-1:0]    act_q, alt_q, act_d;
  logic [DLY_W-1:0] slp_q, hib_q;

  always_comb begin
    act_d = act_q;
    if (wr_en_i && wr_addr_i == A_TACT) act_d = wr_data_i[TW-1:0];
    if (cpu_set_i) act_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '1;
      alt_q <= '1;
      slp_q <= DLY_W'(SLP_RST);
      hib_q <= DLY_W'(HIB_RST);
    end else begin
      act_q <= act_d;
      if (wr_en_i && wr_addr_i == A_TALT) alt_q <= wr_data_i[TW-1:0];
      if (wr_en_i && wr_addr_i == A_DLY) begin
        slp_q <= wr_data_i[DLY_W-1:0];
        hib_q <= wr_data_i[DW-1:DLY_W];
      end
    end
  end

  assign act_tmpl_o = act_q;
  assign alt_tmpl_o = alt_q;
  assign dly_slp_o  = slp_q;
  assign dly_hib_o  = hib_q;

  // R6
  cpu_set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_set_i |=> act_q[0]);
endmodule

// File: rtl/pwr_wake_sel.sv
module pwr_wake_sel
  import pwr_mode_pkg::*;
#(
  parameter int unsigned NS = N_SRC
) (
  input  pm_mode_e        mode_i,
  input  logic [NS-1:0]   wake_i,
  input  logic            irq_i,
  output logic            hit_o
);
  logic [NS-1:0] acc;
  logic          running;

  assign running = (mode_i == PM_ACT) || (mode_i == PM_ALT);

  for (genvar g = 0; g < NS; g++) begin : g_src
    if (g == SRC_PIN) begin : g_pin
      assign acc[g] = wake_i[g] && (mode_i != PM_WAKE);
    end else begin : g_oth
      assign acc[g] = wake_i[g] && (running || mode_i == PM_SLP);
    end
  end

  assign hit_o = (|acc) || (irq_i && running);
endmodule

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_req_i,
  input  logic             hit_i,
  input  logic             done_i,
  input  logic [DLY_W-1:0] dly_slp_i,
  input  logic [DLY_W-1:0] dly_hib_i,
  output pm_mode_e         state_o,
  output logic             load_o,
  output logic [DLY_W-1:0] load_val_o,
  output logic             cpu_set_o
);
  pm_mode_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = dly_slp_i;
    cpu_set_o  = 1'b0;
    unique case (st_q)
      PM_ACT: begin
        cpu_set_o = hit_i;
        if (mode_wr_i) st_d = pm_mode_e'({1'b0, mode_req_i});
      end
      PM_ALT: begin
        if (hit_i) begin
          st_d      = PM_ACT;
          cpu_set_o = 1'b1;
        end else if (mode_wr_i) begin
          st_d = pm_mode_e'({1'b0, mode_req_i});
        end
      end
      PM_SLP: if (hit_i) begin
        st_d   = PM_WAKE;
        load_o = 1'b1;
      end
      PM_HIB: if (hit_i) begin
        st_d       = PM_WAKE;
        load_o     = 1'b1;
        load_val_o = dly_hib_i;
      end
      PM_WAKE: if (done_i) begin
        st_d      = PM_ACT;
        cpu_set_o = 1'b1;
      end
      default: st_d = PM_ACT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= PM_ACT;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  // R9
  wake_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PM_WAKE && done_i) |=> st_q == PM_ACT);
  // R10
  wake_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == PM_WAKE |=> (st_q == PM_WAKE || st_q == PM_ACT));
  // R8
  hib_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PM_HIB && !hit_i) |=> st_q == PM_HIB);
  // R5
  alt_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PM_ALT && hit_i) |=> st_q == PM_ACT);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int unsigned N_RES   = 7,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned SLP_RST = 4,
  parameter int unsigned HIB_RST = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [2*DLY_W-1:0]   wr_data_i,
  input  logic [N_SRC-1:0]     wake_i,
  input  logic                 irq_i,
  output logic [N_RES-1:0]     clk_en_o,
  output logic                 cpu_en_o,
  output logic [2:0]           mode_o
);
  localparam int unsigned TW = N_RES + 1;

  logic [TW-1:0]    act_tmpl, alt_tmpl;
  logic [DLY_W-1:0] dly_slp, dly_hib, load_val;
  logic             cpu_set, hit, done, load, mode_wr;
  pm_mode_e         mode_q;

  assign mode_wr = wr_en_i && (wr_addr_i == A_MODE);

  pwr_cfg_regs #(
    .TW(TW), .DLY_W(DLY_W), .SLP_RST(SLP_RST), .HIB_RST(HIB_RST)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cpu_set_i (cpu_set),
    .act_tmpl_o(act_tmpl),
    .alt_tmpl_o(alt_tmpl),
    .dly_slp_o (dly_slp),
    .dly_hib_o (dly_hib)
  );

  pwr_wake_sel #(.NS(N_SRC)) u_sel (
    .mode_i(mode_q), .wake_i, .irq_i, .hit_o(hit)
  );

  pwr_wake_timer #(.W(DLY_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(load), .val_i(load_val), .done_o(done)
  );

  pwr_mode_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i, .rst_ni,
    .mode_wr_i (mode_wr),
    .mode_req_i(wr_data_i[1:0]),
    .hit_i     (hit),
    .done_i    (done),
    .dly_slp_i (dly_slp),
    .dly_hib_i (dly_hib),
    .state_o   (mode_q),
    .load_o    (load),
    .load_val_o(load_val),
    .cpu_set_o (cpu_set)
  );

  always_comb begin
    unique case (mode_q)
      PM_ACT:  {clk_en_o, cpu_en_o} = act_tmpl;
      PM_ALT:  {clk_en_o, cpu_en_o} = alt_tmpl;
      default: {clk_en_o, cpu_en_o} = '0;
    endcase
  end

  assign mode_o = mode_q;

  // R4
  gated_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_SLP || mode_q == PM_HIB || mode_q == PM_WAKE)
      |-> (clk_en_o == '0 && !cpu_en_o));
  // R9
  cpu_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == PM_WAKE && mode_q == PM_ACT) |-> cpu_en_o);
endmodule

// File: tb/pwr_mode_ctrl_test.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_test;
  localparam int N_RES = 7;
  localparam int DLY_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [2*DLY_W-1:0] wr_data = '0;
  logic [4:0] wake = '0;
  logic irq = 1'b0;
  logic [N_RES-1:0] clk_en;
  logic cpu_en;
  logic [2:0] mode;

  int total = 0, bad = 0;
  logic [7:0] atpl;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.N_RES(N_RES), .DLY_W(DLY_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wake_i(wake), .irq_i(irq),
    .clk_en_o(clk_en), .cpu_en_o(cpu_en), .mode_o(mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d[2*DLY_W-1:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] w, input logic i);
    @(negedge clk);
    wake = w; irq = i;
    @(negedge clk);
    wake = '0; irq = 1'b0;
  endtask

  // counts cycles mode_o reports Waking, with an optional mode write mid-way
  task automatic wait_wake(output int n, input bit poke);
    n = 0;
    while (mode == 3'd4 && n < 400) begin
      n++;
      if (poke && n == 2) begin
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'd2;
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 mode", mode, 0);
    chk("R1 cpu", cpu_en, 1);
    chk("R1 clk", clk_en, 7'h7f);

    // R3 active sweep
    for (int t = 0; t < 256; t++) begin
      wr(2'd1, t);
      chk("R3 act clk", clk_en, t >> 1);
      chk("R3 act cpu", cpu_en, t & 1);
    end
    // R2 alt entry, R3 alt sweep
    wr(2'd0, 1);
    chk("R2 alt", mode, 1);
    for (int t = 0; t < 256; t++) begin
      wr(2'd2, t);
      chk("R3 alt clk", clk_en, t >> 1);
      chk("R3 alt cpu", cpu_en, t & 1);
    end
    // R5 alt wake by irq and by each source
    wr(2'd1, 8'h34);
    chk("R5 alt still", mode, 1);
    pulse(5'd0, 1'b1);
    chk("R5 irq mode", mode, 0);
    chk("R5 cpu", cpu_en, 1);
    chk("R5 clk", clk_en, 7'h1a);
    for (int s = 0; s < 5; s++) begin
      wr(2'd0, 1);
      pulse(5'(1 << s), 1'b0);
      chk("R5 src mode", mode, 0);
    end

    // R6 cpu self-disable, woken by irq then by a source
    wr(2'd1, 8'hA4);
    chk("R6 cpu off", cpu_en, 0);
    chk("R6 clk", clk_en, 7'h52);
    pulse(5'd0, 1'b1);
    chk("R6 irq cpu", cpu_en, 1);
    chk("R6 mode", mode, 0);
    wr(2'd1, 8'hA4);
    pulse(5'b01000, 1'b0);
    chk("R6 src cpu", cpu_en, 1);

    // R7 R9 sleep wake per source and delay
    for (int s = 0; s < 5; s++) begin
      for (int d = 0; d < 4; d++) begin
        atpl = 8'(8'h10 + s * 16 + d * 2);
        wr(2'd1, atpl);
        wr(2'd3, (9 << 8) | (d + s));
        wr(2'd0, 2);
        chk("R2 sleep", mode, 2);
        chk("R4 slp clk", clk_en, 0);
        chk("R4 slp cpu", cpu_en, 0);
        pulse(5'(1 << s), 1'b0);
        wait_wake(n, 1'b0);
        chk("R7 R9 slp cycles", n, d + s + 1);
        chk("R9 mode act", mode, 0);
        chk("R9 cpu forced", cpu_en, 1);
        chk("R4 tmpl kept", clk_en, atpl >> 1);
      end
    end

    // R10 mode write in sleep ignored; R4 template write in sleep kept
    wr(2'd3, (3 << 8) | 6);
    wr(2'd0, 2);
    wr(2'd0, 0);
    chk("R10 slp write", mode, 2);
    wr(2'd0, 3);
    chk("R10 slp write hib", mode, 2);
    wr(2'd1, 8'h6a);
    chk("R4 slp wr clk", clk_en, 0);
    pulse(5'b00100, 1'b0);
    wait_wake(n, 1'b1);
    chk("R10 wake write ign", n, 7);
    chk("R10 mode act", mode, 0);
    chk("R4 new tmpl", clk_en, 7'h35);
    chk("R9 cpu", cpu_en, 1);

    // R8 hibernate
    for (int d = 0; d < 5; d++) begin
      wr(2'd3, ((d * 3) << 8) | 1);
      wr(2'd0, 3);
      chk("R2 hib", mode, 3);
      chk("R4 hib clk", clk_en, 0);
      for (int s = 1; s < 5; s++) begin
        pulse(5'(1 << s), 1'b0);
        chk("R8 ignored src", mode, 3);
      end
      pulse(5'd0, 1'b1);
      chk("R8 ignored irq", mode, 3);
      wr(2'd0, 0);
      chk("R10 hib write", mode, 3);
      pulse(5'b00001, 1'b0);
      wait_wake(n, 1'b0);
      chk("R8 R9 hib cycles", n, d * 3 + 1);
      chk("R9 hib act", mode, 0);
      chk("R9 hib cpu", cpu_en, 1);
    end

    // R1 reset again mid-run
    wr(2'd1, 8'h00);
    wr(2'd0, 2);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 re mode", mode, 0);
    chk("R1 re clk", clk_en, 7'h7f);
    chk("R1 re cpu", cpu_en, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule